// File: doc/BRIEF.md
# Overlapped Fetch and Write-Back Instruction Sequencer

This block steps a very small 8-bit accumulator machine through its instructions one clock cycle at a time, over a single byte-wide memory bus. Each cycle it presents one address and either reads a byte or, in the write cycle of a store, drives a byte with the write strobe high. It holds a program counter, an instruction register, the A and Y registers and the N and Z flags. The machine knows six instructions: decrement Y, increment Y, copy Y into A, branch when Z is clear, load A with an immediate byte, and store A to a 16-bit absolute address.

Register results do not land in the instruction's last bus cycle. A result is computed during the following opcode fetch. It is committed one cycle after that, while the next instruction is in its second cycle. Small pipelined control state carries the pending destination and flags, because by then the instruction register already holds the next opcode. A branch that immediately follows a register instruction reads Z through a bypass from this pending stage. A store gets no such overlap: its write cycle occupies the bus, and the next opcode fetch waits until it ends.

The trace outputs show, every cycle, whether an opcode is being fetched, the instruction register and the A, Y, N and Z values. With these a bench can compare cycle counts and bus activity against hand-built tables.

Top module: `fetch_overlap_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the bus address is START_ADDR (default 0x0200), the write strobe is low, the cycle is an opcode fetch, and A, Y, N and Z read zero.
- R2: Opcode encodings are 0x01 decrement Y, 0x02 increment Y, 0x03 copy Y to A, 0x10 branch if Z clear, 0x20 load A immediate, and 0x30 store A absolute (low address byte first). Every other byte is a two-cycle no-op that changes no register or flag.
- R3: Decrement Y, increment Y, copy Y to A, load immediate and the no-op each take two cycles. The first fetches the opcode. The second reads the next address, and that byte is discarded except for load immediate. The next opcode fetch follows at once, at the address after the instruction.
- R4: For an instruction whose opcode fetch is cycle k, its new register value and flags appear on the trace from cycle k+4. The trace instruction register already shows the next opcode in cycle k+3.
- R5: Each register instruction sets N to bit 7 of its result and Z to whether the result is zero. Decrementing Y from 0x00 gives 0xFF with N set and Z clear. Store, branch and no-op leave both flags unchanged.
- R6: The branch reads its signed offset in its second cycle and evaluates Z including any pending write-back. When not taken it takes two cycles. When taken it adds a third cycle that reads the address after the offset. The fetch then occurs at that address plus the sign-extended offset.
- R7: A store takes four cycles: opcode, low address byte, high address byte, then one write cycle. In the write cycle the strobe is high, the address is {high, low}, and the write data is A. The strobe is high in no other cycle.
- R8: The cycle after a store's write cycle is the next opcode fetch, at the address following the store. No register write-back is pending during a write cycle.
- R9: The fetch trace is high exactly in opcode-fetch cycles. The trace instruction register shows each opcode from the cycle after its fetch until the next fetch completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_rdata | input | DATA_W | Byte read from memory at bus_addr in the same cycle |
| bus_addr | output | ADDR_W | Registered memory address for the current cycle |
| bus_wdata | output | DATA_W | Registered store data, meaningful when bus_we is high |
| bus_we | output | 1 | Write strobe, high only in a store's write cycle |
| trace_fetch | output | 1 | High in opcode-fetch cycles |
| trace_ir | output | DATA_W | Instruction register |
| trace_a | output | DATA_W | Committed A register |
| trace_y | output | DATA_W | Committed Y register |
| trace_n | output | 1 | Committed N flag |
| trace_z | output | 1 | Committed Z flag |

## Verification
The bench targets a branch placed directly behind a Y update whose Z value is still only in the write-back stage. A design without the bypass would take the wrong path, and the fetch addresses would drift from the table. Y is wrapped from 0x00 to 0xFF and back. A register that committed one cycle early, or used the wrong flag, would show on the trace in cycle k+3 or would flip N and Z wrongly. The bench also checks stores whose data comes from a register written just before them, an unknown opcode that must leave A, N and Z untouched, and a backward taken branch. A store that overlapped its fetch, or a branch that skipped its extra cycle, would each shift every later address.

// File: rtl/fos_pkg.sv
package fos_pkg;

  localparam logic [7:0] OPC_DECY  = 8'h01;
  localparam logic [7:0] OPC_INCY  = 8'h02;
  localparam logic [7:0] OPC_MOVYA = 8'h03;
  localparam logic [7:0] OPC_BRNZ  = 8'h10;
  localparam logic [7:0] OPC_LDAI  = 8'h20;
  localparam logic [7:0] OPC_STAA  = 8'h30;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_SECOND,
    ST_ADRH,
    ST_WRITE,
    ST_BRANCH
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_DECY,
    OP_INCY,
    OP_MOVYA,
    OP_LDAI,
    OP_BRNZ,
    OP_STAA
  } op_kind_t;

  typedef enum logic {
    DST_A,
    DST_Y
  } dst_t;

endpackage

// File: rtl/fos_decode.sv
module fos_decode
  import fos_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opcode,
  output op_kind_t          kind
);

  always_comb begin
    kind = OP_NOP;
    if (opcode == DATA_W'(OPC_DECY))       kind = OP_DECY;
    else if (opcode == DATA_W'(OPC_INCY))  kind = OP_INCY;
    else if (opcode == DATA_W'(OPC_MOVYA)) kind = OP_MOVYA;
    else if (opcode == DATA_W'(OPC_BRNZ))  kind = OP_BRNZ;
    else if (opcode == DATA_W'(OPC_LDAI))  kind = OP_LDAI;
    else if (opcode == DATA_W'(OPC_STAA))  kind = OP_STAA;
  end

endmodule

// File: rtl/fos_alu.sv
module fos_alu
  import fos_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_kind_t          kind,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output dst_t              dst,
  output logic              neg,
  output logic              zero
);

  always_comb begin
    result = y_in;
    dst    = DST_Y;
    unique case (kind)
      OP_DECY:  begin result = y_in - DATA_W'(1); dst = DST_Y; end
      OP_INCY:  begin result = y_in + DATA_W'(1); dst = DST_Y; end
      OP_MOVYA: begin result = y_in;              dst = DST_A; end
      OP_LDAI:  begin result = imm;               dst = DST_A; end
      default:  begin result = y_in;              dst = DST_Y; end
    endcase
    neg  = result[DATA_W-1];
    zero = (result == '0);
  end

endmodule

// File: rtl/fos_regs.sv
module fos_regs
  import fos_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  op_kind_t          issue_kind,
  input  logic [DATA_W-1:0] issue_imm,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_y,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_z_eff,
  output logic              pipe_busy
);

  // execute stage: live during the next opcode fetch
  logic              ex_valid;
  op_kind_t          ex_kind;
  logic [DATA_W-1:0] ex_imm;

  // write-back stage: live during the next instruction's second cycle
  logic              wb_valid;
  dst_t              wb_dst;
  logic [DATA_W-1:0] wb_data;
  logic              wb_n;
  logic              wb_z;

  logic [DATA_W-1:0] alu_res;
  dst_t              alu_dst;
  logic              alu_n;
  logic              alu_z;

  fos_alu #(.DATA_W(DATA_W)) u_alu (
    .kind   (ex_kind),
    .y_in   (reg_y),
    .imm    (ex_imm),
    .result (alu_res),
    .dst    (alu_dst),
    .neg    (alu_n),
    .zero   (alu_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_kind  <= OP_NOP;
      ex_imm   <= '0;
    end else begin
      ex_valid <= issue_valid;
      ex_kind  <= issue_kind;
      ex_imm   <= issue_imm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_dst   <= DST_Y;
      wb_data  <= '0;
      wb_n     <= 1'b0;
      wb_z     <= 1'b0;
    end else begin
      wb_valid <= ex_valid;
      wb_dst   <= alu_dst;
      wb_data  <= alu_res;
      wb_n     <= alu_n;
      wb_z     <= alu_z;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a  <= '0;
      reg_y  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (wb_valid) begin
      if (wb_dst == DST_A) reg_a <= wb_data;
      else                 reg_y <= wb_data;
      flag_n <= wb_n;
      flag_z <= wb_z;
    end
  end

  assign flag_z_eff = wb_valid ? wb_z : flag_z;
  assign pipe_busy  = ex_valid | wb_valid;

  AST_Y_ONLY_AT_WB: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_y) |-> ($past(wb_valid) && $past(wb_dst) == DST_Y)); // R4

  AST_A_ONLY_AT_WB: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_a) |-> ($past(wb_valid) && $past(wb_dst) == DST_A)); // R4

  AST_FLAGS_ONLY_AT_WB: assert property (@(posedge clk) disable iff (rst)
    (!$stable(flag_n) || !$stable(flag_z)) |-> $past(wb_valid)); // R5

endmodule

// File: rtl/fetch_overlap_seq.sv
module fetch_overlap_seq
  import fos_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              trace_fetch,
  output logic [DATA_W-1:0] trace_ir,
  output logic [DATA_W-1:0] trace_a,
  output logic [DATA_W-1:0] trace_y,
  output logic              trace_n,
  output logic              trace_z
);

  localparam int EXT_W = ADDR_W - DATA_W;

  seq_state_t        state;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ab_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] adr_lo;
  logic [DATA_W-1:0] br_off;

  op_kind_t          dec_kind;
  logic              issue_valid;
  logic [DATA_W-1:0] reg_a;
  logic [DATA_W-1:0] reg_y;
  logic              flag_n;
  logic              flag_z;
  logic              flag_z_eff;
  logic              pipe_busy;

  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] br_tgt;

  fos_decode #(.DATA_W(DATA_W)) u_decode (
    .opcode (ir),
    .kind   (dec_kind)
  );

  assign issue_valid = (state == ST_SECOND) &&
                       (dec_kind == OP_DECY || dec_kind == OP_INCY ||
                        dec_kind == OP_MOVYA || dec_kind == OP_LDAI);

  fos_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_kind  (dec_kind),
    .issue_imm   (bus_rdata),
    .reg_a       (reg_a),
    .reg_y       (reg_y),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_z_eff  (flag_z_eff),
    .pipe_busy   (pipe_busy)
  );

  assign pc_inc = pc + ADDR_W'(1);
  assign br_tgt = pc + {{EXT_W{br_off[DATA_W-1]}}, br_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      pc     <= START_ADDR;
      ab_q   <= START_ADDR;
      we_q   <= 1'b0;
      wd_q   <= '0;
      ir     <= '0;
      adr_lo <= '0;
      br_off <= '0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          ir    <= bus_rdata;
          pc    <= pc_inc;
          ab_q  <= pc_inc;
          state <= ST_SECOND;
        end
        ST_SECOND: begin
          state <= ST_FETCH;
          ab_q  <= pc;
          unique case (dec_kind)
            OP_LDAI: begin
              pc   <= pc_inc;
              ab_q <= pc_inc;
            end
            OP_BRNZ: begin
              pc     <= pc_inc;
              ab_q   <= pc_inc;
              br_off <= bus_rdata;
              if (!flag_z_eff) state <= ST_BRANCH;
            end
            OP_STAA: begin
              pc     <= pc_inc;
              ab_q   <= pc_inc;
              adr_lo <= bus_rdata;
              state  <= ST_ADRH;
            end
            default: begin
              pc <= pc;
            end
          endcase
        end
        ST_ADRH: begin
          pc    <= pc_inc;
          ab_q  <= ADDR_W'({bus_rdata, adr_lo});
          we_q  <= 1'b1;
          wd_q  <= reg_a;
          state <= ST_WRITE;
        end
        ST_WRITE: begin
          we_q  <= 1'b0;
          ab_q  <= pc;
          state <= ST_FETCH;
        end
        ST_BRANCH: begin
          pc    <= br_tgt;
          ab_q  <= br_tgt;
          state <= ST_FETCH;
        end
        default: begin
          state <= ST_FETCH;
        end
      endcase
    end
  end

  assign bus_addr    = ab_q;
  assign bus_we      = we_q;
  assign bus_wdata   = wd_q;
  assign trace_fetch = (state == ST_FETCH);
  assign trace_ir    = ir;
  assign trace_a     = reg_a;
  assign trace_y     = reg_y;
  assign trace_n     = flag_n;
  assign trace_z     = flag_z;

  AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (trace_fetch && bus_addr == START_ADDR && !bus_we)); // R1

  AST_NO_BACK_TO_BACK_FETCH: assert property (@(posedge clk) disable iff (rst)
    trace_fetch |=> !trace_fetch); // R3

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we); // R7

  AST_FETCH_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> trace_fetch); // R8

  AST_NO_WB_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> !pipe_busy); // R8

endmodule

// File: tb/fetch_overlap_seq_bench.sv
module fetch_overlap_seq_bench;

  localparam int          ADDR_W = 16;
  localparam int          DATA_W = 8;
  localparam int          MEM_AW = 10;
  localparam logic [15:0] START  = 16'h0200;

  typedef struct {
    logic [15:0] addr;
    logic        fetch;
    logic        we;
    logic [7:0]  wd;
    string       req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] bus_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_we;
  logic              trace_fetch;
  logic [DATA_W-1:0] trace_ir;
  logic [DATA_W-1:0] trace_a;
  logic [DATA_W-1:0] trace_y;
  logic              trace_n;
  logic              trace_z;

  logic [7:0] mem [0:(1<<MEM_AW)-1];
  item_t      exp_q[$];
  int         checks   = 0;
  int         failures = 0;
  bit         mon_done = 1'b0;

  always #10 clk = ~clk;

  fetch_overlap_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .START_ADDR(START)) u_fetch_overlap_seq (
    .clk         (clk),
    .rst         (rst),
    .bus_rdata   (bus_rdata),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .trace_fetch (trace_fetch),
    .trace_ir    (trace_ir),
    .trace_a     (trace_a),
    .trace_y     (trace_y),
    .trace_n     (trace_n),
    .trace_z     (trace_z)
  );

  assign bus_rdata = mem[bus_addr[MEM_AW-1:0]];

  always @(posedge clk) begin
    if (!rst && bus_we) mem[bus_addr[MEM_AW-1:0]] <= bus_wdata;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int addr, input logic [7:0] val);
    mem[addr[MEM_AW-1:0]] = val;
  endtask

  // driver: push one expected bus cycle into the scoreboard
  task automatic push(input logic [15:0] a, input bit f, input bit w, input logic [7:0] d, input string req);
    item_t it;
    it.addr  = a;
    it.fetch = f;
    it.we    = w;
    it.wd    = d;
    it.req   = req;
    exp_q.push_back(it);
  endtask

  task automatic reg_checks(input int cyc);
    case (cyc)
      0:  begin
            chk("R1", "a", trace_a, 8'h00); chk("R1", "y", trace_y, 8'h00);
            chk("R1", "n", trace_n, 0);     chk("R1", "z", trace_z, 0);
          end
      1:  chk("R9", "ir after decy fetch", trace_ir, 8'h01);
      3:  begin
            chk("R4", "y not yet committed", trace_y, 8'h00);
            chk("R9", "ir holds next opcode", trace_ir, 8'h10);
          end
      4:  begin
            chk("R4", "y committed", trace_y, 8'hFF);
            chk("R5", "n after 00-1", trace_n, 1); chk("R5", "z after 00-1", trace_z, 0);
          end
      8:  chk("R4", "a before copy commit", trace_a, 8'h00);
      9:  chk("R4", "a after copy commit", trace_a, 8'hFF);
      10: chk("R9", "ir during store write", trace_ir, 8'h30);
      15: begin
            chk("R5", "y wraps to 00", trace_y, 8'h00);
            chk("R5", "z after inc", trace_z, 1); chk("R5", "n after inc", trace_n, 0);
          end
      19: begin
            chk("R5", "a load 80", trace_a, 8'h80);
            chk("R5", "n load 80", trace_n, 1); chk("R5", "z load 80", trace_z, 0);
          end
      24: chk("R4", "z still old during wb", trace_z, 0);
      25: begin
            chk("R5", "a load 00", trace_a, 8'h00); chk("R5", "z load 00", trace_z, 1);
          end
      35: chk("R4", "y after two decs", trace_y, 8'hFE);
      37: begin
            chk("R4", "a after copy", trace_a, 8'hFE); chk("R5", "n after copy", trace_n, 1);
          end
      40: chk("R9", "ir unknown opcode", trace_ir, 8'hFF);
      43: begin
            chk("R2", "nop keeps a", trace_a, 8'hFE);
            chk("R2", "nop keeps n", trace_n, 1); chk("R2", "nop keeps z", trace_z, 0);
          end
      default: ;
    endcase
  endtask

  // monitor: pop and compare one expected item per cycle
  initial begin
    item_t it;
    int    cyc;
    cyc = 0;
    wait (rst == 1'b0);
    while (exp_q.size() != 0) begin
      @(negedge clk);
      it = exp_q.pop_front();
      chk(it.req, $sformatf("addr c%0d", cyc), bus_addr, it.addr);
      chk(it.req, $sformatf("fetch c%0d", cyc), trace_fetch, it.fetch);
      chk(it.req, $sformatf("we c%0d", cyc), bus_we, it.we);
      if (it.we) chk(it.req, $sformatf("wdata c%0d", cyc), bus_wdata, it.wd);
      reg_checks(cyc);
      cyc++;
    end
    mon_done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = 8'h00;
    // program image
    poke('h200, 8'h01); poke('h201, 8'h10); poke('h202, 8'h02); poke('h203, 8'h20);
    poke('h204, 8'h55); poke('h205, 8'h03); poke('h206, 8'h30); poke('h207, 8'h00);
    poke('h208, 8'h03); poke('h209, 8'h02); poke('h20A, 8'h10); poke('h20B, 8'h05);
    poke('h20C, 8'h20); poke('h20D, 8'h80); poke('h20E, 8'h30); poke('h20F, 8'h10);
    poke('h210, 8'h03); poke('h211, 8'h20); poke('h212, 8'h00); poke('h213, 8'h10);
    poke('h214, 8'hFE); poke('h215, 8'h30); poke('h216, 8'h20); poke('h217, 8'h03);
    poke('h218, 8'h01); poke('h219, 8'h01); poke('h21A, 8'h03); poke('h21B, 8'h30);
    poke('h21C, 8'h30); poke('h21D, 8'h03); poke('h21E, 8'hFF); poke('h21F, 8'h30);
    poke('h220, 8'h40); poke('h221, 8'h03); poke('h222, 8'h10); poke('h223, 8'hFE);

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "addr in reset", bus_addr, START);
    chk("R1", "we in reset", bus_we, 0);

    // expected bus table, one entry per cycle
    push(16'h0200, 1, 0, 0, "R1");   // c0 decrement Y
    push(16'h0201, 0, 0, 0, "R3");
    push(16'h0201, 1, 0, 0, "R3");   // c2 branch
    push(16'h0202, 0, 0, 0, "R6");   // bypassed Z=0: taken
    push(16'h0203, 0, 0, 0, "R6");
    push(16'h0205, 1, 0, 0, "R6");   // c5 copy Y to A
    push(16'h0206, 0, 0, 0, "R3");
    push(16'h0206, 1, 0, 0, "R3");   // c7 store
    push(16'h0207, 0, 0, 0, "R7");
    push(16'h0208, 0, 0, 0, "R7");
    push(16'h0300, 0, 1, 8'hFF, "R7");
    push(16'h0209, 1, 0, 0, "R8");   // c11 increment Y
    push(16'h020A, 0, 0, 0, "R3");
    push(16'h020A, 1, 0, 0, "R3");   // c13 branch
    push(16'h020B, 0, 0, 0, "R6");   // bypassed Z=1: not taken
    push(16'h020C, 1, 0, 0, "R6");   // c15 load 80
    push(16'h020D, 0, 0, 0, "R3");
    push(16'h020E, 1, 0, 0, "R3");   // c17 store
    push(16'h020F, 0, 0, 0, "R7");
    push(16'h0210, 0, 0, 0, "R7");
    push(16'h0310, 0, 1, 8'h80, "R7");
    push(16'h0211, 1, 0, 0, "R8");   // c21 load 00
    push(16'h0212, 0, 0, 0, "R3");
    push(16'h0213, 1, 0, 0, "R3");   // c23 branch
    push(16'h0214, 0, 0, 0, "R6");   // not taken
    push(16'h0215, 1, 0, 0, "R6");   // c25 store
    push(16'h0216, 0, 0, 0, "R7");
    push(16'h0217, 0, 0, 0, "R7");
    push(16'h0320, 0, 1, 8'h00, "R7");
    push(16'h0218, 1, 0, 0, "R8");   // c29 decrement Y
    push(16'h0219, 0, 0, 0, "R3");
    push(16'h0219, 1, 0, 0, "R3");   // c31 decrement Y
    push(16'h021A, 0, 0, 0, "R3");
    push(16'h021A, 1, 0, 0, "R3");   // c33 copy Y to A
    push(16'h021B, 0, 0, 0, "R3");
    push(16'h021B, 1, 0, 0, "R3");   // c35 store
    push(16'h021C, 0, 0, 0, "R7");
    push(16'h021D, 0, 0, 0, "R7");
    push(16'h0330, 0, 1, 8'hFE, "R7");
    push(16'h021E, 1, 0, 0, "R8");   // c39 unknown opcode
    push(16'h021F, 0, 0, 0, "R2");
    push(16'h021F, 1, 0, 0, "R2");   // c41 store
    push(16'h0220, 0, 0, 0, "R7");
    push(16'h0221, 0, 0, 0, "R7");
    push(16'h0340, 0, 1, 8'hFE, "R7");
    push(16'h0222, 1, 0, 0, "R8");   // c45 backward branch
    push(16'h0223, 0, 0, 0, "R6");
    push(16'h0224, 0, 0, 0, "R6");
    push(16'h0222, 1, 0, 0, "R6");
    push(16'h0223, 0, 0, 0, "R6");
    push(16'h0224, 0, 0, 0, "R6");
    push(16'h0222, 1, 0, 0, "R6");

    @(posedge clk);
    #1 rst = 1'b0;

    wait (mon_done == 1'b1);
    @(negedge clk);
    chk("R7", "mem 0300", mem['h300], 8'hFF);
    chk("R7", "mem 0310", mem['h310], 8'h80);
    chk("R7", "mem 0320", mem['h320], 8'h00);
    chk("R7", "mem 0330", mem['h330], 8'hFE);
    chk("R7", "mem 0340", mem['h340], 8'hFE);
    chk("R2", "skipped load left no trace", mem['h204], 8'h55);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule